// File: doc/BRIEF.md
# Radio SPI Command Master

This block drives a command-oriented radio transceiver over a four-wire SPI link on behalf of a local controller. The controller hands over one request at a time through a valid/ready handshake. The request names a command kind and supplies an opcode, a 16-bit register address, an 8-bit buffer offset, a byte count and a single data byte. The block turns that request into a framed serial transaction. It first waits for the transceiver to report that it is not busy. It then pulls chip select low, clocks the header and payload bytes and stores any returned bytes. Finally it releases chip select and raises a one-cycle completion pulse.

Payload bytes move through a local byte array. The controller loads this array before a write-type command and reads it back after a read-type command. Each command kind has its own header layout. Some kinds place filler bytes between the header and the returned data; those filler bytes make up the transceiver's turnaround time. A transmit offset pointer tracks where the next buffer write would land in the transceiver's data buffer.

Top module: `radio_cmd_master`

## Requirements
- R1: The serial link follows SPI mode 0. SCK is low whenever chip select is high, MOSI only changes while SCK is low, MISO is sampled on the SCK rising edge, and bytes go most significant bit first. Chip select stays low from the first byte of a command to the end of its last byte.
- R2: With the parameter USE_BUSY set to 1, chip select does not fall while the synchronised busy input is high. With USE_BUSY set to 0, the busy input is ignored and a command starts even while busy is held high.
- R3: Kind code 3 (register read) sends 0x1D, the address high byte, the address low byte and one 0x00 filler byte. It then clocks one more 0x00 byte and stores the returned value at array index 0.
- R4: Kind code 2 (register write) sends 0x0D, the address high byte, the address low byte and the data byte, and nothing else. The array is left unchanged.
- R5: Kind code 1 (opcode read) sends the given opcode and a 0x00 status byte whose reply is dropped. It then sends N bytes of 0x00 and stores the N replies at array indexes 0 to N-1.
- R6: Kind code 0 (opcode write) sends the given opcode followed by array entries 0 to N-1.
- R7: Kind code 4 (buffer write) sends 0x0E, the offset and array entries 0 to N-1. The transmit pointer output is loaded with the offset at the start of the command and advances by one for each payload byte, modulo 256. No other kind changes the pointer.
- R8: Kind code 5 (buffer read) sends 0x1E, the offset and one 0x00 filler byte. It then sends N bytes of 0x00 and stores the N replies at array indexes 0 to N-1.
- R9: Each SCK half period lasts sck_half system cycles, and a value of 0 counts as 1. Chip select falls at least one half period before the first SCK rising edge.
- R10: req_ready is high only while the block is idle, and a request is taken in the cycle where both req_valid and req_ready are high. done is a single-cycle pulse that only appears while chip select is high.
- R11: A byte count of 0 for kinds 0, 1, 4 and 5 sends only the header bytes and leaves the array unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_kind | input | 3 | Command kind code |
| req_opcode | input | 8 | Opcode for the opcode read and write kinds |
| req_addr | input | 16 | Register address |
| req_offset | input | 8 | Transceiver buffer start offset |
| req_len | input | 8 | Payload byte count N |
| req_wdata | input | 8 | Register write data byte |
| sck_half | input | DIV_W | System cycles per SCK half period |
| pl_wr_en | input | 1 | Controller write strobe into the local array |
| pl_wr_idx | input | log2(BUF_DEPTH) | Controller write index |
| pl_wr_data | input | 8 | Controller write byte |
| pl_rd_idx | input | log2(BUF_DEPTH) | Controller read index |
| pl_rd_data | output | 8 | Array byte at pl_rd_idx (combinational) |
| buf_tx_ptr | output | 8 | Transmit offset pointer |
| done | output | 1 | One-cycle completion pulse |
| busy_in | input | 1 | Transceiver busy line (asynchronous) |
| spi_csn | output | 1 | Chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench builds two copies of the block with BUF_DEPTH 256 and DIV_W 8. The first copy has USE_BUSY 1 and runs every kind at half-period settings of 0 to 4. It covers byte counts of 0 and 255 and a buffer write whose pointer wraps past 0xFF, so that every header layout and the full array span are reached. The second copy has USE_BUSY 0 and its busy input tied high, which shows that the wait is really skipped when the line is configured as absent. A bus model answers each frame position with a salted byte pattern, so the captured bytes prove which replies were stored and which filler replies were dropped.

// File: rtl/radio_cmd_pkg.sv
package radio_cmd_pkg;

    localparam int CMD_LEN_W  = 8;
    localparam int HDR_MAX    = 4;
    localparam int HDR_SEL_W  = $clog2(HDR_MAX);
    localparam int HDR_CNT_W  = $clog2(HDR_MAX + 1);
    localparam int POS_W      = CMD_LEN_W + 1;

    localparam logic [7:0] OPC_REG_RD = 8'h1D;
    localparam logic [7:0] OPC_REG_WR = 8'h0D;
    localparam logic [7:0] OPC_BUF_WR = 8'h0E;
    localparam logic [7:0] OPC_BUF_RD = 8'h1E;
    localparam logic [7:0] FILL_BYTE  = 8'h00;

    typedef enum logic [2:0] {
        K_OP_WR  = 3'd0,
        K_OP_RD  = 3'd1,
        K_REG_WR = 3'd2,
        K_REG_RD = 3'd3,
        K_BUF_WR = 3'd4,
        K_BUF_RD = 3'd5
    } cmd_kind_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_BUSY,
        S_CS_SETUP,
        S_XFER,
        S_CS_HOLD,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic [HDR_MAX-1:0][7:0] hdr;
        logic [HDR_CNT_W-1:0]    hdr_n;
        logic [POS_W-1:0]        data_n;
        logic                    src_buf;
        logic                    cap_buf;
        logic                    ptr_adv;
    } frame_plan_t;

    function automatic frame_plan_t plan_frame(
        input logic [2:0]           kind,
        input logic [7:0]           opcode,
        input logic [15:0]          addr,
        input logic [7:0]           offset,
        input logic [CMD_LEN_W-1:0] len,
        input logic [7:0]           wdata
    );
        frame_plan_t p;
        p        = '0;
        p.data_n = {1'b0, len};
        case (kind)
            K_OP_RD: begin
                p.hdr[0]  = opcode;
                p.hdr[1]  = FILL_BYTE;
                p.hdr_n   = HDR_CNT_W'(2);
                p.cap_buf = 1'b1;
            end
            K_REG_WR: begin
                p.hdr[0]  = OPC_REG_WR;
                p.hdr[1]  = addr[15:8];
                p.hdr[2]  = addr[7:0];
                p.hdr[3]  = wdata;
                p.hdr_n   = HDR_CNT_W'(4);
                p.data_n  = '0;
            end
            K_REG_RD: begin
                p.hdr[0]  = OPC_REG_RD;
                p.hdr[1]  = addr[15:8];
                p.hdr[2]  = addr[7:0];
                p.hdr[3]  = FILL_BYTE;
                p.hdr_n   = HDR_CNT_W'(4);
                p.data_n  = POS_W'(1);
                p.cap_buf = 1'b1;
            end
            K_BUF_WR: begin
                p.hdr[0]  = OPC_BUF_WR;
                p.hdr[1]  = offset;
                p.hdr_n   = HDR_CNT_W'(2);
                p.src_buf = 1'b1;
                p.ptr_adv = 1'b1;
            end
            K_BUF_RD: begin
                p.hdr[0]  = OPC_BUF_RD;
                p.hdr[1]  = offset;
                p.hdr[2]  = FILL_BYTE;
                p.hdr_n   = HDR_CNT_W'(3);
                p.cap_buf = 1'b1;
            end
            default: begin
                p.hdr[0]  = opcode;
                p.hdr_n   = HDR_CNT_W'(1);
                p.src_buf = 1'b1;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/radio_spi_byte_shifter.sv
module radio_spi_byte_shifter #(
    parameter int DIV_W  = 8,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic [DIV_W-1:0]  half,
    input  logic              miso,
    output logic              sck,
    output logic              mosi,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              done,
    output logic              active
);
    localparam int BIT_W = $clog2(BYTE_W);

    logic              active_q;
    logic              sck_q;
    logic              done_q;
    logic [BYTE_W-1:0] tx_q;
    logic [BYTE_W-1:0] rx_q;
    logic [BIT_W-1:0]  bit_q;
    logic [DIV_W-1:0]  tmr_q;
    logic              half_end;

    assign half_end = (tmr_q == half - DIV_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            sck_q    <= 1'b0;
            done_q   <= 1'b0;
            tx_q     <= '0;
            rx_q     <= '0;
            bit_q    <= '0;
            tmr_q    <= '0;
        end else begin
            done_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    tx_q     <= tx_byte;
                    bit_q    <= '0;
                    tmr_q    <= '0;
                    sck_q    <= 1'b0;
                end
            end else if (half_end) begin
                tmr_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[BYTE_W-2:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    if (bit_q == BIT_W'(BYTE_W - 1)) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        bit_q <= bit_q + BIT_W'(1);
                        tx_q  <= {tx_q[BYTE_W-2:0], 1'b0};
                    end
                end
            end else begin
                tmr_q <= tmr_q + DIV_W'(1);
            end
        end
    end

    assign sck     = sck_q;
    assign mosi    = active_q & tx_q[BYTE_W-1];
    assign rx_byte = rx_q;
    assign done    = done_q;
    assign active  = active_q;

endmodule

// File: rtl/radio_byte_buffer.sv
module radio_byte_buffer #(
    parameter int DEPTH  = 256,
    parameter int BYTE_W = 8,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_widx,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              cap_we,
    input  logic [IDX_W-1:0]  cap_widx,
    input  logic [BYTE_W-1:0] cap_wdata,
    input  logic [IDX_W-1:0]  host_ridx,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic [IDX_W-1:0]  seq_ridx,
    output logic [BYTE_W-1:0] seq_rdata
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // capture from the serial side wins over a host write to the same slot
    always_ff @(posedge clk) begin
        if (cap_we) begin
            mem[cap_widx] <= cap_wdata;
        end
        if (host_we && !(cap_we && cap_widx == host_widx)) begin
            mem[host_widx] <= host_wdata;
        end
    end

    assign host_rdata = mem[host_ridx];
    assign seq_rdata  = mem[seq_ridx];

endmodule

// File: rtl/radio_cmd_master.sv
module radio_cmd_master
    import radio_cmd_pkg::*;
#(
    parameter int BUF_DEPTH = 256,
    parameter int DIV_W     = 8,
    parameter bit USE_BUSY  = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         req_valid,
    output logic                         req_ready,
    input  logic [2:0]                   req_kind,
    input  logic [7:0]                   req_opcode,
    input  logic [15:0]                  req_addr,
    input  logic [7:0]                   req_offset,
    input  logic [CMD_LEN_W-1:0]         req_len,
    input  logic [7:0]                   req_wdata,
    input  logic [DIV_W-1:0]             sck_half,
    input  logic                         pl_wr_en,
    input  logic [$clog2(BUF_DEPTH)-1:0] pl_wr_idx,
    input  logic [7:0]                   pl_wr_data,
    input  logic [$clog2(BUF_DEPTH)-1:0] pl_rd_idx,
    output logic [7:0]                   pl_rd_data,
    output logic [7:0]                   buf_tx_ptr,
    output logic                         done,
    input  logic                         busy_in,
    output logic                         spi_csn,
    output logic                         spi_sck,
    output logic                         spi_mosi,
    input  logic                         spi_miso
);
    localparam int IDX_W  = $clog2(BUF_DEPTH);
    localparam int SYNC_N = 2;

    seq_state_e       state;
    frame_plan_t      plan_q;
    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] total;
    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] gap_q;
    logic [7:0]       ptr_q;
    logic             csn_q;
    logic [SYNC_N-1:0] busy_sync;
    logic             busy_s;

    logic             in_data;
    logic [POS_W-1:0] data_pos;
    logic [IDX_W-1:0] data_idx;
    logic [7:0]       seq_rdata;
    logic [7:0]       tx_byte;
    logic             sh_start;
    logic             sh_done;
    logic             sh_active;
    logic [7:0]       sh_rx;
    logic             cap_we;
    logic             gap_end;

    // busy line arrives from another clock domain
    always_ff @(posedge clk) begin
        if (rst) busy_sync <= '1;
        else     busy_sync <= {busy_sync[SYNC_N-2:0], busy_in};
    end
    assign busy_s = busy_sync[SYNC_N-1];

    assign total    = POS_W'(plan_q.hdr_n) + plan_q.data_n;
    assign in_data  = (pos_q >= POS_W'(plan_q.hdr_n));
    assign data_pos = pos_q - POS_W'(plan_q.hdr_n);
    assign data_idx = data_pos[IDX_W-1:0];
    assign gap_end  = (gap_q == half_q - DIV_W'(1));

    always_comb begin
        if (!in_data)            tx_byte = plan_q.hdr[pos_q[HDR_SEL_W-1:0]];
        else if (plan_q.src_buf) tx_byte = seq_rdata;
        else                     tx_byte = FILL_BYTE;
    end

    assign sh_start = (state == S_XFER) && !sh_active && !sh_done;
    assign cap_we   = (state == S_XFER) && sh_done && in_data && plan_q.cap_buf;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            plan_q <= '0;
            pos_q  <= '0;
            half_q <= DIV_W'(1);
            gap_q  <= '0;
            ptr_q  <= '0;
            csn_q  <= 1'b1;
        end else begin
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        plan_q <= plan_frame(req_kind, req_opcode, req_addr,
                                             req_offset, req_len, req_wdata);
                        half_q <= (sck_half == '0) ? DIV_W'(1) : sck_half;
                        pos_q  <= '0;
                        if (req_kind == K_BUF_WR) ptr_q <= req_offset;
                        state  <= S_WAIT_BUSY;
                    end
                end
                S_WAIT_BUSY: begin
                    if (!USE_BUSY || !busy_s) begin
                        csn_q <= 1'b0;
                        gap_q <= '0;
                        state <= S_CS_SETUP;
                    end
                end
                S_CS_SETUP: begin
                    if (gap_end) begin
                        gap_q <= '0;
                        state <= S_XFER;
                    end else begin
                        gap_q <= gap_q + DIV_W'(1);
                    end
                end
                S_XFER: begin
                    if (sh_done) begin
                        if (in_data && plan_q.ptr_adv) ptr_q <= ptr_q + 8'd1;
                        pos_q <= pos_q + POS_W'(1);
                        if (pos_q + POS_W'(1) == total) begin
                            gap_q <= '0;
                            state <= S_CS_HOLD;
                        end
                    end
                end
                S_CS_HOLD: begin
                    if (gap_end) begin
                        csn_q <= 1'b1;
                        state <= S_DONE;
                    end else begin
                        gap_q <= gap_q + DIV_W'(1);
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    radio_spi_byte_shifter #(
        .DIV_W  (DIV_W),
        .BYTE_W (8)
    ) u_shift (
        .clk     (clk),
        .rst     (rst),
        .start   (sh_start),
        .tx_byte (tx_byte),
        .half    (half_q),
        .miso    (spi_miso),
        .sck     (spi_sck),
        .mosi    (spi_mosi),
        .rx_byte (sh_rx),
        .done    (sh_done),
        .active  (sh_active)
    );

    radio_byte_buffer #(
        .DEPTH  (BUF_DEPTH),
        .BYTE_W (8),
        .IDX_W  (IDX_W)
    ) u_buf (
        .clk        (clk),
        .host_we    (pl_wr_en),
        .host_widx  (pl_wr_idx),
        .host_wdata (pl_wr_data),
        .cap_we     (cap_we),
        .cap_widx   (data_idx),
        .cap_wdata  (sh_rx),
        .host_ridx  (pl_rd_idx),
        .host_rdata (pl_rd_data),
        .seq_ridx   (data_idx),
        .seq_rdata  (seq_rdata)
    );

    assign req_ready  = (state == S_IDLE);
    assign done       = (state == S_DONE);
    assign spi_csn    = csn_q;
    assign buf_tx_ptr = ptr_q;

endmodule

// File: rtl/radio_cmd_master_chk.sv
module radio_cmd_master_chk #(
    parameter bit USE_BUSY = 1'b1
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic spi_csn,
    input logic spi_sck,
    input logic spi_mosi,
    input logic busy_s
);
    // R1
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_csn |-> !spi_sck);

    // R1
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sck |-> $stable(spi_mosi));

    // R2
    busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_csn) |-> (!USE_BUSY || !$past(busy_s)));

    // R10
    ready_csn_chk: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> spi_csn);

    // R10
    done_csn_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> spi_csn);

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

endmodule

bind radio_cmd_master radio_cmd_master_chk #(.USE_BUSY(USE_BUSY)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .done      (done),
    .spi_csn   (spi_csn),
    .spi_sck   (spi_sck),
    .spi_mosi  (spi_mosi),
    .busy_s    (busy_s)
);

// File: tb/radio_cmd_master_tb.sv
`timescale 1ns/1ps
module radio_cmd_master_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic        req_valid = 0, req_ready;
    logic [2:0]  req_kind = 0;
    logic [7:0]  req_opcode = 0, req_offset = 0, req_len = 0, req_wdata = 0;
    logic [15:0] req_addr = 0;
    logic [7:0]  sck_half = 1;
    logic        pl_wr_en = 0;
    logic [7:0]  pl_wr_idx = 0, pl_wr_data = 0, pl_rd_idx = 0, pl_rd_data;
    logic [7:0]  buf_tx_ptr;
    logic        done, busy_in = 0;
    logic        spi_csn, spi_sck, spi_mosi;
    logic        spi_miso = 0;

    radio_cmd_master #(.BUF_DEPTH(256), .DIV_W(8), .USE_BUSY(1'b1)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_opcode(req_opcode), .req_addr(req_addr),
        .req_offset(req_offset), .req_len(req_len), .req_wdata(req_wdata),
        .sck_half(sck_half), .pl_wr_en(pl_wr_en), .pl_wr_idx(pl_wr_idx),
        .pl_wr_data(pl_wr_data), .pl_rd_idx(pl_rd_idx), .pl_rd_data(pl_rd_data),
        .buf_tx_ptr(buf_tx_ptr), .done(done), .busy_in(busy_in),
        .spi_csn(spi_csn), .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

    // second copy: busy configured as absent, busy tied high
    logic       nb_valid = 0, nb_ready, nb_done, nb_csn, nb_sck, nb_mosi;
    logic [7:0] nb_rd, nb_ptr;
    radio_cmd_master #(.BUF_DEPTH(256), .DIV_W(8), .USE_BUSY(1'b0)) u_nobusy (
        .clk(clk), .rst(rst), .req_valid(nb_valid), .req_ready(nb_ready),
        .req_kind(3'd2), .req_opcode(8'h00), .req_addr(16'h1234),
        .req_offset(8'h00), .req_len(8'h00), .req_wdata(8'h55),
        .sck_half(8'd1), .pl_wr_en(1'b0), .pl_wr_idx(8'h00),
        .pl_wr_data(8'h00), .pl_rd_idx(8'h00), .pl_rd_data(nb_rd),
        .buf_tx_ptr(nb_ptr), .done(nb_done), .busy_in(1'b1),
        .spi_csn(nb_csn), .spi_sck(nb_sck), .spi_mosi(nb_mosi), .spi_miso(1'b0));

    int tests = 0, fails = 0;
    bit finished = 0;

    task automatic chk(bit ok, string req, string what, int act, int expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // ---------------- bus model of the transceiver ----------------
    logic [7:0] salt = 0;
    logic [7:0] mlog [0:300];
    int         mlog_n = 0, bitc = 0;
    logic [7:0] sh_in = 0, resp_sh = 0;

    function automatic logic [7:0] resp_byte(int k);
        return 8'(k * 29 + 7) ^ salt;
    endfunction

    always @(posedge spi_sck) if (!spi_csn) sh_in = {sh_in[6:0], spi_mosi};
    always @(negedge spi_sck) if (!spi_csn) begin
        bitc++;
        if (bitc == 8) begin
            mlog[mlog_n] = sh_in;
            mlog_n++;
            bitc = 0;
            resp_sh = resp_byte(mlog_n);
        end else begin
            resp_sh = {resp_sh[6:0], 1'b0};
        end
        spi_miso = resp_sh[7];
    end

    // timing monitor for SCK high width and chip select setup
    int hi_run = 0, last_hi = 0, setup_cnt = 0;
    bit seen_sck = 0;
    always @(negedge clk) begin
        if (spi_sck) begin
            hi_run++;
            seen_sck = 1;
        end else if (hi_run != 0) begin
            last_hi = hi_run;
            hi_run = 0;
        end
        if (!spi_csn && !seen_sck) setup_cnt++;
    end

    // ---------------- expected model ----------------
    logic [7:0] shadow [0:255];
    logic [7:0] ef [0:300];
    int         en = 0;
    logic [7:0] exp_ptr = 0;

    task automatic build_frame(int kind, logic [7:0] op, logic [15:0] addr,
                               logic [7:0] off, int len, logic [7:0] wd);
        en = 0;
        case (kind)
            0: begin ef[0] = op; en = 1;
                     for (int i = 0; i < len; i++) ef[en++] = shadow[i]; end
            1: begin ef[0] = op; ef[1] = 8'h00; en = 2;
                     for (int i = 0; i < len; i++) ef[en++] = 8'h00; end
            2: begin ef[0] = 8'h0D; ef[1] = addr[15:8]; ef[2] = addr[7:0];
                     ef[3] = wd; en = 4; end
            3: begin ef[0] = 8'h1D; ef[1] = addr[15:8]; ef[2] = addr[7:0];
                     ef[3] = 8'h00; ef[4] = 8'h00; en = 5; end
            4: begin ef[0] = 8'h0E; ef[1] = off; en = 2;
                     for (int i = 0; i < len; i++) ef[en++] = shadow[i]; end
            default: begin ef[0] = 8'h1E; ef[1] = off; ef[2] = 8'h00; en = 3;
                     for (int i = 0; i < len; i++) ef[en++] = 8'h00; end
        endcase
    endtask

    task automatic host_wr(int idx, logic [7:0] d);
        @(negedge clk);
        pl_wr_en = 1; pl_wr_idx = 8'(idx); pl_wr_data = d;
        @(negedge clk);
        pl_wr_en = 0;
        shadow[idx] = d;
    endtask

    task automatic check_buffer(string req);
        int bad = -1;
        logic [7:0] got = 0;
        for (int i = 0; i < 256; i++) begin
            pl_rd_idx = 8'(i);
            #0.1;
            if (bad < 0 && pl_rd_data !== shadow[i]) begin bad = i; got = pl_rd_data; end
        end
        chk(bad < 0, req, $sformatf("array byte %0d", bad), got, bad < 0 ? 0 : shadow[bad]);
    endtask

    task automatic run_cmd(int kind, logic [7:0] op, logic [15:0] addr, logic [7:0] off,
                           int len, logic [7:0] wd, int h, string req);
        int w = 0;
        int eh = (h == 0) ? 1 : h;
        int bad = -1;
        int hdr = (kind == 1) ? 2 : (kind == 3) ? 4 : (kind == 5) ? 3 : 0;
        build_frame(kind, op, addr, off, len, wd);
        salt = 8'($urandom);
        mlog_n = 0; bitc = 0; resp_sh = resp_byte(0); spi_miso = resp_sh[7];
        hi_run = 0; last_hi = 0; setup_cnt = 0; seen_sck = 0;
        @(negedge clk);
        req_kind = 3'(kind); req_opcode = op; req_addr = addr; req_offset = off;
        req_len = 8'(len); req_wdata = wd; sck_half = 8'(h); req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(req_ready == 0, "R10", "ready while busy", req_ready, 0);
        while (!done && w < 20000) begin @(negedge clk); w++; end
        chk(done == 1, req, "done seen", done, 1);
        chk(spi_csn == 1, "R10", "csn high with done", spi_csn, 1);
        @(negedge clk);
        chk(done == 0, "R10", "done single pulse", done, 0);
        chk(mlog_n == en, req, "frame length", mlog_n, en);
        for (int i = 0; i < en && i < mlog_n; i++)
            if (bad < 0 && mlog[i] !== ef[i]) bad = i;
        chk(bad < 0, req, $sformatf("frame byte %0d", bad),
            bad < 0 ? 0 : mlog[bad], bad < 0 ? 0 : ef[bad]);
        if (kind == 1 || kind == 5)
            for (int i = 0; i < len; i++) shadow[i] = resp_byte(hdr + i);
        if (kind == 3) shadow[0] = resp_byte(4);
        if (kind == 4) exp_ptr = 8'(off + len);
        check_buffer(req);
        chk(buf_tx_ptr == exp_ptr, "R7", "tx pointer", buf_tx_ptr, exp_ptr);
        chk(last_hi == eh, "R9", "sck high width", last_hi, eh);
        chk(setup_cnt >= eh, "R9", "csn setup", setup_cnt, eh);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int w;
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        chk(spi_csn == 1, "R1", "reset csn", spi_csn, 1);
        chk(spi_sck == 0, "R1", "reset sck", spi_sck, 0);
        chk(req_ready == 1, "R10", "reset ready", req_ready, 1);
        chk(done == 0, "R10", "reset done", done, 0);
        chk(buf_tx_ptr == 0, "R7", "reset ptr", buf_tx_ptr, 0);

        for (int i = 0; i < 256; i++) host_wr(i, 8'($urandom));

        // directed cases
        run_cmd(3, 8'h00, 16'h0740, 8'h00, 0, 8'h00, 2, "R3");
        run_cmd(2, 8'h00, 16'hA5C3, 8'h00, 0, 8'h96, 1, "R4");
        run_cmd(1, 8'h12, 16'h0000, 8'h00, 3, 8'h00, 3, "R5");
        run_cmd(0, 8'h8A, 16'h0000, 8'h00, 2, 8'h00, 1, "R6");
        run_cmd(4, 8'h00, 16'h0000, 8'hFE, 5, 8'h00, 2, "R7");
        run_cmd(5, 8'h00, 16'h0000, 8'h10, 4, 8'h00, 4, "R8");
        run_cmd(1, 8'hC0, 16'h0000, 8'h00, 0, 8'h00, 1, "R11");
        run_cmd(5, 8'h00, 16'h0000, 8'h20, 0, 8'h00, 1, "R11");
        run_cmd(4, 8'h00, 16'h0000, 8'h33, 0, 8'h00, 1, "R11");
        run_cmd(0, 8'h80, 16'h0000, 8'h00, 0, 8'h00, 0, "R9");
        run_cmd(1, 8'h13, 16'h0000, 8'h00, 255, 8'h00, 1, "R5");
        run_cmd(4, 8'h00, 16'h0000, 8'h01, 255, 8'h00, 1, "R7");

        // busy gating on the main copy
        busy_in = 1;
        fork
            run_cmd(2, 8'h00, 16'h08E7, 8'h00, 0, 8'h38, 1, "R2");
            begin
                repeat (25) @(negedge clk);
                chk(spi_csn == 1, "R2", "csn held while busy", spi_csn, 1);
                busy_in = 0;
            end
        join

        // busy absent: starts with busy tied high
        @(negedge clk);
        nb_valid = 1;
        @(negedge clk);
        nb_valid = 0;
        w = 0;
        while (!nb_done && w < 2000) begin @(negedge clk); w++; end
        chk(nb_done == 1, "R2", "no-busy copy completes", nb_done, 1);

        // constrained random mix
        for (int t = 0; t < 16; t++) begin
            int k = $urandom % 6;
            int n = $urandom % 24;
            int h = 1 + $urandom % 3;
            if (k == 0 || k == 4)
                for (int i = 0; i < n; i++) host_wr(i, 8'($urandom));
            run_cmd(k, 8'($urandom), 16'($urandom), 8'($urandom), n, 8'($urandom), h,
                    k == 0 ? "R6" : k == 1 ? "R5" : k == 2 ? "R4" :
                    k == 3 ? "R3" : k == 4 ? "R7" : "R8");
        end

        // R1 R10: idle bus after all traffic
        @(negedge clk);
        chk(spi_csn == 1 && spi_sck == 0, "R1", "idle bus", {spi_csn, spi_sck}, 2);
        finish_run();
    end

endmodule